// File: doc/BRIEF.md
# Flash Block Write-Protect Range Manager

This block holds a write-protect state for each block of a flash array whose block count is a parameter. Software sets a start and an end block index, then issues a range command: unlock, lock, lock-tight, or unlock-all. A state machine then visits the blocks in the window one at a time, one per clock, and applies the rules of that command. A three-bit status register holds the last state the block wrote. A sticky error flag reports a visit that reached a block index past the end of the array. A program or erase engine reads the state of any block through a combinational query port.

The walker has three states. `ST_IDLE` waits for a command. `ST_WALK` visits one block per clock. `ST_DONE` lasts one cycle and drives the done pulse. The transitions are as follows:
- `ST_IDLE` goes to `ST_WALK` when it accepts a known command with a non-empty window.
- `ST_IDLE` goes to `ST_DONE` when it accepts a known command whose start is greater than its end. Unlock-all never takes this path.
- `ST_WALK` goes to `ST_DONE` on the last block, on a stopping lock-tight block, or on an out-of-range index.
- `ST_DONE` goes back to `ST_IDLE`.

Top module: `block_lock_mgr`

## Requirements
- R1: After reset every block reads locked, the status reads 3'b010, both range registers read 0, and busy, done and the error flag are low.
- R2: Block states use a one-hot code: lock-tight is 3'b001, locked is 3'b010 and unlocked is 3'b100. `query_state` shows the state of block `query_idx` in the same cycle.
- R3: A start-register write stores the low `$clog2(NUM_BLOCKS)` bits of `wr_data` into both the start and the end register. An end-register write changes only the end register. When both writes are asserted in the same cycle, the start write wins.
- R4: Code 8'h23 (unlock) visits blocks from start to end inclusive and sets each visited block to unlocked.
- R5: Code 8'h2A (lock) visits the same window and sets each visited block to locked.
- R6: Unlock, lock and unlock-all end at the first lock-tight block they meet. That block and every later block keep their states.
- R7: Code 8'h2C (lock-tight) visits the window, leaves unlocked blocks unchanged, and sets every other visited block to lock-tight.
- R8: Code 8'h27 (unlock-all) ignores the range registers and visits blocks 0 to NUM_BLOCKS-1 under the rule of R6.
- R9: A visit to an index at or beyond NUM_BLOCKS ends the walk without a write and sets the error flag. The flag stays set until the next command is accepted, which clears it.
- R10: A command is accepted in one cycle, and the walk then writes one block per clock. A window of k blocks ends with a one-cycle done pulse k+1 cycles after acceptance. An empty window (start > end) gives done in the first cycle after acceptance. Busy is high from acceptance through the done cycle.
- R11: Commands issued while busy, and codes other than the four listed, are ignored. They start no walk, raise no done, and change no block.
- R12: The status register takes the value of every block write and keeps that value in every other cycle. Skips, stops and errors leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_start | input | 1 | Write `wr_data` to the start register (and the end register) |
| wr_end | input | 1 | Write `wr_data` to the end register |
| wr_data | input | DATA_W | Range value; only the low index bits are kept |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_code | input | 8 | Command code |
| query_idx | input | $clog2(NUM_BLOCKS) | Block to query |
| query_state | output | 3 | One-hot state of the queried block |
| range_start | output | $clog2(NUM_BLOCKS) | Start register |
| range_end | output | $clog2(NUM_BLOCKS) | End register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| cmd_err | output | 1 | Out-of-range visit seen in the last command |
| wp_status | output | 3 | Last state written |

## Verification
The assertions assume that `rst_n` is low for at least one clock edge and that `wr_start` is low while reset is asserted, because one property looks at the cycle before. The bench drives every input at the falling edge and keeps the strobes low during and right after reset. It uses a block count that is not a power of two, so index values past the array can be written and the error path becomes reachable. One sequence deliberately asserts `cmd_valid` while the block is busy, which is legal input. Once the walk state is settled, every expected value is a block state, the status value or the error flag, read at the ports.

// File: rtl/block_lock_pkg.sv
package block_lock_pkg;

    localparam logic [2:0] WP_TIGHT    = 3'b001;
    localparam logic [2:0] WP_LOCKED   = 3'b010;
    localparam logic [2:0] WP_UNLOCKED = 3'b100;

    localparam logic [7:0] OP_UNLOCK     = 8'h23;
    localparam logic [7:0] OP_UNLOCK_ALL = 8'h27;
    localparam logic [7:0] OP_LOCK       = 8'h2A;
    localparam logic [7:0] OP_TIGHT      = 8'h2C;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } walk_state_e;

    function automatic logic op_known(input logic [7:0] code);
        return (code == OP_UNLOCK) || (code == OP_UNLOCK_ALL) ||
               (code == OP_LOCK)   || (code == OP_TIGHT);
    endfunction

endpackage

// File: rtl/blk_wp_store.sv
module blk_wp_store
    import block_lock_pkg::*;
#(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [2:0]    wval,
    input  logic [IW-1:0] ridx,
    output logic [2:0]    rval,
    input  logic [IW-1:0] qidx,
    output logic [2:0]    qval
);

    logic [2:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[g] <= WP_LOCKED;
            else if (we && (widx == IW'(g)))
                cells[g] <= wval;
        end
    end

    always_comb begin
        rval = WP_LOCKED;
        for (int i = 0; i < N; i++)
            if (ridx == IW'(i)) rval = cells[i];
    end

    always_comb begin
        qval = WP_LOCKED;
        for (int i = 0; i < N; i++)
            if (qidx == IW'(i)) qval = cells[i];
    end

endmodule

// File: rtl/blk_range_regs.sv
module blk_range_regs #(
    parameter int IW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic          wr_end,
    input  logic [DW-1:0] wr_data,
    output logic [IW-1:0] start_q,
    output logic [IW-1:0] end_q
);

    logic [IW-1:0] masked;
    logic          unused_hi;

    assign masked    = wr_data[IW-1:0];
    assign unused_hi = ^wr_data[DW-1:IW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (wr_start) begin
            start_q <= masked;
            end_q   <= masked;
        end else if (wr_end) begin
            end_q   <= masked;
        end
    end

endmodule

// File: rtl/blk_walk_fsm.sv
module blk_walk_fsm
    import block_lock_pkg::*;
#(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    input  logic [IW-1:0] rng_start,
    input  logic [IW-1:0] rng_end,
    input  logic [2:0]    cur_val,
    output logic [IW-1:0] cur_idx,
    output logic          we,
    output logic [2:0]    wval,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [2:0]    status
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    walk_state_e   state, nxt;
    logic [IW-1:0] cur, last;
    logic [7:0]    op;
    logic          accept, in_range, at_last;
    logic [2:0]    target;

    assign accept   = (state == ST_IDLE) && cmd_valid && op_known(cmd_code);
    assign in_range = (32'(cur) < 32'(N));
    assign at_last  = (cur == last);
    assign cur_idx  = cur;

    always_comb begin
        unique case (op)
            OP_LOCK:  target = WP_LOCKED;
            OP_TIGHT: target = WP_TIGHT;
            default:  target = WP_UNLOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and write strobe
    always_comb begin
        nxt  = state;
        we   = 1'b0;
        wval = target;
        unique case (state)
            ST_IDLE: begin
                if (accept)
                    nxt = ((cmd_code == OP_UNLOCK_ALL) || (rng_start <= rng_end))
                          ? ST_WALK : ST_DONE;
            end
            ST_WALK: begin
                if (!in_range) begin
                    nxt = ST_DONE;
                end else if (op == OP_TIGHT) begin
                    we = (cur_val != WP_UNLOCKED);
                    if (at_last) nxt = ST_DONE;
                end else if (cur_val == WP_TIGHT) begin
                    nxt = ST_DONE;
                end else begin
                    we = 1'b1;
                    if (at_last) nxt = ST_DONE;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= '0;
            last   <= '0;
            op     <= '0;
            err    <= 1'b0;
            status <= WP_LOCKED;
        end else if (accept) begin
            op  <= cmd_code;
            err <= 1'b0;
            if (cmd_code == OP_UNLOCK_ALL) begin
                cur  <= '0;
                last <= LAST_IDX;
            end else begin
                cur  <= rng_start;
                last <= rng_end;
            end
        end else if (state == ST_WALK) begin
            if (we)        status <= wval;
            if (!in_range) err    <= 1'b1;
            cur <= cur + 1'b1;
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/block_lock_mgr.sv
module block_lock_mgr #(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_start,
    input  logic                          wr_end,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          cmd_valid,
    input  logic [7:0]                    cmd_code,
    input  logic [$clog2(NUM_BLOCKS)-1:0] query_idx,
    output logic [2:0]                    query_state,
    output logic [$clog2(NUM_BLOCKS)-1:0] range_start,
    output logic [$clog2(NUM_BLOCKS)-1:0] range_end,
    output logic                          busy,
    output logic                          done,
    output logic                          cmd_err,
    output logic [2:0]                    wp_status
);

    localparam int IW = $clog2(NUM_BLOCKS);

    logic [IW-1:0] cur_idx;
    logic [2:0]    cur_val;
    logic          arr_we;
    logic [2:0]    arr_wval;

    blk_range_regs #(.IW(IW), .DW(DATA_W)) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .wr_data  (wr_data),
        .start_q  (range_start),
        .end_q    (range_end)
    );

    blk_walk_fsm #(.N(NUM_BLOCKS), .IW(IW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .rng_start (range_start),
        .rng_end   (range_end),
        .cur_val   (cur_val),
        .cur_idx   (cur_idx),
        .we        (arr_we),
        .wval      (arr_wval),
        .busy      (busy),
        .done      (done),
        .err       (cmd_err),
        .status    (wp_status)
    );

    blk_wp_store #(.N(NUM_BLOCKS), .IW(IW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .widx  (cur_idx),
        .wval  (arr_wval),
        .ridx  (cur_idx),
        .rval  (cur_val),
        .qidx  (query_idx),
        .qval  (query_state)
    );

endmodule

// File: rtl/block_lock_mgr_chk.sv
module block_lock_mgr_chk #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          busy,
    input logic          cmd_err,
    input logic [2:0]    wp_status,
    input logic          wr_start,
    input logic [IW-1:0] range_start,
    input logic [IW-1:0] range_end,
    input logic          arr_we,
    input logic [IW-1:0] cur_idx,
    input logic [2:0]    arr_wval,
    input logic [2:0]    cur_val
);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_write_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_write_in_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (32'(cur_idx) < 32'(N)));

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> done);

    assert_tight_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && (cur_val == 3'b001)) |-> (arr_wval == 3'b001));

    assert_start_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (range_start == range_end));

    assert_status_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wp_status) == 1);

    assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_we |=> $stable(wp_status));

endmodule

bind block_lock_mgr block_lock_mgr_chk #(.N(NUM_BLOCKS), .IW($clog2(NUM_BLOCKS))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .busy        (busy),
    .cmd_err     (cmd_err),
    .wp_status   (wp_status),
    .wr_start    (wr_start),
    .range_start (range_start),
    .range_end   (range_end),
    .arr_we      (arr_we),
    .cur_idx     (cur_idx),
    .arr_wval    (arr_wval),
    .cur_val     (cur_val)
);

// File: tb/block_lock_mgr_test.sv
module block_lock_mgr_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_start = 1'b0, wr_end = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic [IW-1:0] query_idx = '0;
    logic [2:0]    query_state, wp_status;
    logic [IW-1:0] range_start, range_end;
    logic          busy, done, cmd_err;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_lock_mgr #(.NUM_BLOCKS(NB), .DATA_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
        .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .query_idx(query_idx), .query_state(query_state),
        .range_start(range_start), .range_end(range_end), .busy(busy),
        .done(done), .cmd_err(cmd_err), .wp_status(wp_status)
    );

    // {cmd, start, end, chk_idx, exp_state, exp_status, exp_err}
    localparam logic [26:0] VEC [10] = '{
        {8'h23, 4'd2, 4'd5,  4'd3,  3'b100, 3'b100, 1'b0},  // R4
        {8'h2C, 4'd0, 4'd4,  4'd1,  3'b001, 3'b001, 1'b0},  // R7
        {8'h2A, 4'd0, 4'd3,  4'd2,  3'b100, 3'b001, 1'b0},  // R6
        {8'h2A, 4'd3, 4'd6,  4'd4,  3'b010, 3'b010, 1'b0},  // R5
        {8'h23, 4'd9, 4'd14, 4'd11, 3'b100, 3'b100, 1'b1},  // R9
        {8'h27, 4'd0, 4'd0,  4'd6,  3'b010, 3'b100, 1'b0},  // R8
        {8'h2C, 4'd6, 4'd6,  4'd6,  3'b001, 3'b001, 1'b0},  // R7
        {8'h23, 4'd7, 4'd8,  4'd8,  3'b100, 3'b100, 1'b0},  // R4
        {8'h2A, 4'd5, 4'd7,  4'd7,  3'b100, 3'b010, 1'b0},  // R6
        {8'h2A, 4'd9, 4'd2,  4'd9,  3'b100, 3'b010, 1'b0}   // R10
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_start(input logic [15:0] v);
        wr_start = 1'b1; wr_data = v;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic set_end(input logic [15:0] v);
        wr_end = 1'b1; wr_data = v;
        @(negedge clk);
        wr_end = 1'b0;
    endtask

    // returns negedges from the strobe to the done cycle
    task automatic issue(input logic [7:0] code, output int n);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    function automatic int q(input int idx);
        return 0;
    endfunction

    task automatic query(input int idx, output int st);
        query_idx = IW'(idx);
        #1;
        st = int'(query_state);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st, n;
        do_reset();

        // R1 reset state, R2 encoding
        for (int b = 0; b < NB; b++) begin
            query(b, st);
            check("R1 block locked", st, 3'b010);
        end
        check("R1 status", wp_status, 3'b010);
        check("R1 start", range_start, 0);
        check("R1 end", range_end, 0);
        check("R1 busy/done/err", {busy, done, cmd_err}, 0);

        // R3 masking and copy
        set_start(16'h0035);
        check("R3 start masked", range_start, 5);
        check("R3 end copied", range_end, 5);
        set_end(16'h0F0A);
        check("R3 start kept", range_start, 5);
        check("R3 end only", range_end, 10);
        wr_start = 1'b1; wr_end = 1'b1; wr_data = 16'h0003;
        @(negedge clk);
        wr_start = 1'b0; wr_end = 1'b0;
        check("R3 start wins", {range_start, range_end}, {4'd3, 4'd3});

        // table walk
        for (int v = 0; v < 10; v++) begin
            set_start(16'(VEC[v][18:15]));
            set_end(16'(VEC[v][14:11]));
            issue(VEC[v][26:19], n);
            query(int'(VEC[v][10:7]), st);
            check($sformatf("R2/R4-R9 vec%0d state", v), st, int'(VEC[v][6:4]));
            check($sformatf("R12 vec%0d status", v), wp_status, int'(VEC[v][3:1]));
            check($sformatf("R9 vec%0d err", v), cmd_err, int'(VEC[v][0]));
            if (v == 9) check("R10 empty window cycles", n, 1);
        end

        // R11 unknown code
        cmd_valid = 1'b1; cmd_code = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (done || busy) n++;
            @(negedge clk);
        end
        check("R11 unknown code ignored", n, 0);
        query(6, st);
        check("R11 unknown code no change", st, 3'b001);

        // R8 unlock-all from reset, R10 timing
        do_reset();
        issue(8'h27, n);
        check("R10 full walk cycles", n, NB + 1);
        query(0, st);
        check("R8 first block", st, 3'b100);
        query(NB - 1, st);
        check("R8 last block", st, 3'b100);
        check("R12 status after all", wp_status, 3'b100);

        // R11 command while busy, R10 pulse width
        set_start(16'd0);
        set_end(16'd3);
        cmd_valid = 1'b1; cmd_code = 8'h2A;
        @(negedge clk);
        cmd_code = 8'h2C;
        check("R10 busy after accept", busy, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 2;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R10 four-block cycles", n, 5);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        query(0, st);
        check("R11 busy command ignored", st, 3'b010);
        query(3, st);
        check("R5 range end locked", st, 3'b010);
        query(4, st);
        check("R5 outside range kept", st, 3'b100);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule